// File: doc/BRIEF.md
# Four-Mode Significand Rounding Stage

This block is the last step of a single-precision arithmetic datapath, after alignment, addition or multiplication, and normalization. It takes a sign, an 8-bit biased exponent and a 24-bit significand whose top bit is the hidden one. It also takes three extra low-order bits, guard, round and sticky, and a two-bit rounding-mode selector. From these it produces the 23-bit stored fraction and the final exponent.

The block is purely combinational. It decides whether to add one unit in the last kept place, using the mode, the sign and the extra bits. In nearest mode, an exact halfway value goes to the even neighbour. When the increment ripples out of the top of the significand, the result is renormalized: the significand becomes 1.0 and the exponent rises by one.

Three flags are reported. One marks an inexact result. One marks that rounding raised the exponent. One marks that the final exponent reached the all-ones code. The caller decides how to encode infinity from the overflow flag.

Top module: `fp_round_stage`

## Requirements
- R1: With mode 00 (nearest, ties to even) and guard bit 0, the fraction and exponent are passed through unchanged, whatever the round and sticky bits are.
- R2: With mode 00, guard bit 1, and round or sticky set, the significand is incremented by one unit in the last place.
- R3: With mode 00 and an exact tie (guard 1, round 0, sticky 0), the significand is incremented only if its bit 0 is 1. The result therefore always ends in 0.
- R4: With mode 01 (toward zero), the significand is never incremented. The guard, round and sticky bits are simply dropped.
- R5: With mode 10 (toward +infinity), the significand is incremented only when the sign is 0 and at least one of guard, round or sticky is set.
- R6: With mode 11 (toward -infinity), the significand is incremented only when the sign is 1 and at least one of guard, round or sticky is set.
- R7: When an increment carries out of a 24-bit significand of all ones, the fraction output is 0, the exponent output is the input exponent plus one, and exp_bump_o is 1.
- R8: inexact_o is 1 exactly when any of guard, round or sticky is set, in every mode.
- R9: overflow_o is 1 exactly when the adjusted exponent equals 255. This covers an input exponent of 255, or 254 with a rounding carry.
- R10: Without a rounding carry, exp_bump_o is 0 and the exponent output equals the input exponent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sign_i | input | 1 | Sign of the value (1 = negative) |
| exp_i | input | 8 | Biased exponent before rounding |
| sig_i | input | 24 | Normalized significand, bit 23 is the hidden one |
| grs_i | input | 3 | Extra bits {guard, round, sticky}, guard in bit 2 |
| mode_i | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| frac_o | output | 23 | Rounded stored fraction |
| exp_o | output | 8 | Exponent after renormalization (low 8 bits) |
| inexact_o | output | 1 | Discarded bits were nonzero |
| exp_bump_o | output | 1 | Rounding carried out and raised the exponent |
| overflow_o | output | 1 | Adjusted exponent is 255 |

## Verification
Nearest mode is driven with guard-only, guard-plus-round and guard-plus-sticky patterns. Ties are tried on both an even and an odd last bit, which separates the tie-to-even rule from plain round-half-up. The same extra bits are applied under both signs in the directed modes. This shows that each direction follows the sign and that truncation ignores the sign. An all-ones significand is tried at exponents 7, 100 and 254. These cases separate the renormalizing carry from an ordinary increment, and a carry into 255 from a value that stays finite.

// File: rtl/fp_round_pkg.sv
package fp_round_pkg;
    localparam int EXP_W = 8;
    localparam int SIG_W = 24;
    localparam int FRAC_W = SIG_W - 1;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_TO_ZERO   = 2'b01,
        RM_TO_POS    = 2'b10,
        RM_TO_NEG    = 2'b11
    } rmode_e;
endpackage

// File: rtl/fp_round_decide.sv
module fp_round_decide
    import fp_round_pkg::*;
(
    input  logic       sign_i,
    input  logic       lsb_i,
    input  logic [2:0] grs_i,
    input  logic [1:0] mode_i,
    output logic       inc_o,
    output logic       lost_o
);
    logic guard_b;
    logic below_half;
    rmode_e mode;

    assign guard_b    = grs_i[2];
    assign below_half = grs_i[1] | grs_i[0];
    assign lost_o     = guard_b | below_half;
    assign mode       = rmode_e'(mode_i);

    always_comb begin
        unique case (mode)
            RM_NEAR_EVEN: inc_o = guard_b & (below_half | lsb_i);
            RM_TO_ZERO:   inc_o = 1'b0;
            RM_TO_POS:    inc_o = lost_o & ~sign_i;
            RM_TO_NEG:    inc_o = lost_o & sign_i;
            default:      inc_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/fp_round_incr.sv
module fp_round_incr #(
    parameter int EXP_W = 8,
    parameter int SIG_W = 24
) (
    input  logic [EXP_W-1:0] exp_i,
    input  logic [SIG_W-1:0] sig_i,
    input  logic             inc_i,
    output logic [SIG_W-2:0] frac_o,
    output logic [EXP_W-1:0] exp_o,
    output logic             carry_o,
    output logic             ovf_o
);
    localparam logic [EXP_W:0] EXP_MAX = {1'b0, {EXP_W{1'b1}}};

    logic [SIG_W:0]   sum;
    logic [EXP_W:0]   exp_adj;

    assign sum     = {1'b0, sig_i} + {{SIG_W{1'b0}}, inc_i};
    assign carry_o = sum[SIG_W];
    assign exp_adj = {1'b0, exp_i} + {{EXP_W{1'b0}}, carry_o};
    assign exp_o   = exp_adj[EXP_W-1:0];
    assign ovf_o   = (exp_adj >= EXP_MAX);

    always_comb begin
        if (carry_o) frac_o = sum[SIG_W-1:1];
        else         frac_o = sum[SIG_W-2:0];
    end
endmodule

// File: rtl/fp_round_stage.sv
module fp_round_stage
    import fp_round_pkg::*;
(
    input  logic              sign_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [SIG_W-1:0]  sig_i,
    input  logic [2:0]        grs_i,
    input  logic [1:0]        mode_i,
    output logic [FRAC_W-1:0] frac_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic              inexact_o,
    output logic              exp_bump_o,
    output logic              overflow_o
);
    logic inc;

    fp_round_decide i_decide (
        .sign_i (sign_i),
        .lsb_i  (sig_i[0]),
        .grs_i  (grs_i),
        .mode_i (mode_i),
        .inc_o  (inc),
        .lost_o (inexact_o)
    );

    fp_round_incr #(.EXP_W(EXP_W), .SIG_W(SIG_W)) i_incr (
        .exp_i   (exp_i),
        .sig_i   (sig_i),
        .inc_i   (inc),
        .frac_o  (frac_o),
        .exp_o   (exp_o),
        .carry_o (exp_bump_o),
        .ovf_o   (overflow_o)
    );
endmodule

// File: rtl/fp_round_checker.sv
module fp_round_checker (
    input logic        sign_i,
    input logic [7:0]  exp_i,
    input logic [23:0] sig_i,
    input logic [2:0]  grs_i,
    input logic [1:0]  mode_i,
    input logic [22:0] frac_o,
    input logic [7:0]  exp_o,
    input logic        exp_bump_o,
    input logic        overflow_o
);
    logic unchanged;
    assign unchanged = (frac_o == sig_i[22:0]) && (exp_o == exp_i) && !exp_bump_o;

    always_comb begin
        assert_trunc_R4: assert (mode_i != 2'b01 || unchanged);
        assert_pos_dir_R5: assert (!(mode_i == 2'b10 && sign_i) || unchanged);
        assert_neg_dir_R6: assert (!(mode_i == 2'b11 && !sign_i) || unchanged);
        assert_exact_R1: assert (grs_i != 3'b000 || unchanged);
        assert_carry_R7: assert (!exp_bump_o || (frac_o == 23'd0 && sig_i == 24'hFFFFFF));
        assert_no_overflow_R9: assert (!overflow_o || exp_i == 8'hFF || (exp_i == 8'hFE && exp_bump_o));
    end
endmodule

bind fp_round_stage fp_round_checker i_fp_round_checker (
    .sign_i     (sign_i),
    .exp_i      (exp_i),
    .sig_i      (sig_i),
    .grs_i      (grs_i),
    .mode_i     (mode_i),
    .frac_o     (frac_o),
    .exp_o      (exp_o),
    .exp_bump_o (exp_bump_o),
    .overflow_o (overflow_o)
);

// File: tb/test_fp_round_stage.sv
module test_fp_round_stage;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        sign_i;
    logic [7:0]  exp_i;
    logic [23:0] sig_i;
    logic [2:0]  grs_i;
    logic [1:0]  mode_i;
    logic [22:0] frac_o;
    logic [7:0]  exp_o;
    logic        inexact_o, exp_bump_o, overflow_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    fp_round_stage i_fp_round_stage (
        .sign_i(sign_i), .exp_i(exp_i), .sig_i(sig_i), .grs_i(grs_i), .mode_i(mode_i),
        .frac_o(frac_o), .exp_o(exp_o), .inexact_o(inexact_o),
        .exp_bump_o(exp_bump_o), .overflow_o(overflow_o)
    );

    // {sign, exp, sig, grs, mode, exp_frac, exp_exp, inexact, bump, ovf}
    localparam int NV = 16;
    localparam logic [71:0] VEC [NV] = '{
        {1'b0, 8'd100, 24'h800000, 3'b000, 2'd0, 23'h000000, 8'd100, 1'b0, 1'b0, 1'b0},
        {1'b0, 8'd100, 24'h800000, 3'b011, 2'd0, 23'h000000, 8'd100, 1'b1, 1'b0, 1'b0},
        {1'b0, 8'd100, 24'h800000, 3'b110, 2'd0, 23'h000001, 8'd100, 1'b1, 1'b0, 1'b0},
        {1'b0, 8'd100, 24'h800000, 3'b101, 2'd0, 23'h000001, 8'd100, 1'b1, 1'b0, 1'b0},
        {1'b0, 8'd100, 24'h800000, 3'b100, 2'd0, 23'h000000, 8'd100, 1'b1, 1'b0, 1'b0},
        {1'b1, 8'd100, 24'h800001, 3'b100, 2'd0, 23'h000002, 8'd100, 1'b1, 1'b0, 1'b0},
        {1'b0, 8'd100, 24'h800001, 3'b111, 2'd1, 23'h000001, 8'd100, 1'b1, 1'b0, 1'b0},
        {1'b1, 8'd100, 24'hFFFFFF, 3'b111, 2'd1, 23'h7FFFFF, 8'd100, 1'b1, 1'b0, 1'b0},
        {1'b0, 8'd100, 24'h800000, 3'b001, 2'd2, 23'h000001, 8'd100, 1'b1, 1'b0, 1'b0},
        {1'b1, 8'd100, 24'h800000, 3'b111, 2'd2, 23'h000000, 8'd100, 1'b1, 1'b0, 1'b0},
        {1'b1, 8'd100, 24'h800000, 3'b001, 2'd3, 23'h000001, 8'd100, 1'b1, 1'b0, 1'b0},
        {1'b0, 8'd100, 24'h800000, 3'b100, 2'd3, 23'h000000, 8'd100, 1'b1, 1'b0, 1'b0},
        {1'b0, 8'd100, 24'hFFFFFF, 3'b100, 2'd0, 23'h000000, 8'd101, 1'b1, 1'b1, 1'b0},
        {1'b0, 8'd254, 24'hFFFFFF, 3'b010, 2'd2, 23'h000000, 8'd255, 1'b1, 1'b1, 1'b1},
        {1'b0, 8'd254, 24'hFFFFFF, 3'b000, 2'd0, 23'h7FFFFF, 8'd254, 1'b0, 1'b0, 1'b0},
        {1'b1, 8'd7,   24'hFFFFFF, 3'b001, 2'd3, 23'h000000, 8'd8,   1'b1, 1'b1, 1'b0}
    };

    function automatic string vec_req(input int idx);
        case (idx)
            0, 1:    return "R1";
            2, 3:    return "R2";
            4, 5:    return "R3";
            6, 7:    return "R4";
            8, 9:    return "R5";
            10, 11:  return "R6";
            12, 15:  return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic s, input logic [7:0] e, input logic [23:0] m,
                         input logic [2:0] g, input logic [1:0] md);
        @(posedge clk);
        sign_i = s; exp_i = e; sig_i = m; grs_i = g; mode_i = md;
        @(negedge clk);
    endtask

    initial begin
        sign_i = 0; exp_i = 0; sig_i = 0; grs_i = 0; mode_i = 0;
        repeat (3) @(negedge clk);
        // reset state: zero inputs give zero outputs (R10, R8)
        check("R10", {frac_o, exp_o, inexact_o, exp_bump_o, overflow_o}, 34'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][71], VEC[i][70:63], VEC[i][62:39], VEC[i][38:36], VEC[i][35:34]);
            check(vec_req(i), {frac_o, exp_o, inexact_o, exp_bump_o, overflow_o}, VEC[i][33:0]);
        end

        // R8: inexact tracks any discarded bit, all patterns and modes
        for (int md = 0; md < 4; md++) begin
            for (int g = 0; g < 8; g++) begin
                apply(1'b1, 8'd50, 24'hA00000, g[2:0], md[1:0]);
                check("R8", {33'd0, inexact_o}, {33'd0, (g != 0)});
            end
        end

        // R10: increment without carry keeps exponent, no bump
        apply(1'b0, 8'd20, 24'hC00002, 3'b111, 2'd2);
        check("R10", {frac_o, exp_o, inexact_o, exp_bump_o, overflow_o},
              {23'h400003, 8'd20, 1'b1, 1'b0, 1'b0});

        // R9: exponent already at 255 with no rounding
        apply(1'b0, 8'd255, 24'h800000, 3'b000, 2'd1);
        check("R9", {frac_o, exp_o, inexact_o, exp_bump_o, overflow_o},
              {23'h000000, 8'd255, 1'b0, 1'b0, 1'b1});

        // R3: odd tie, negative, each mode distinct
        apply(1'b1, 8'd60, 24'h800003, 3'b100, 2'd0);
        check("R3", {11'd0, frac_o}, {11'd0, 23'h000004});
        apply(1'b1, 8'd60, 24'h800003, 3'b100, 2'd2);
        check("R5", {11'd0, frac_o}, {11'd0, 23'h000003});
        apply(1'b1, 8'd60, 24'h800003, 3'b100, 2'd3);
        check("R6", {11'd0, frac_o}, {11'd0, 23'h000004});

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=5000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule